// File: doc/BRIEF.md
# MSI Doorbell Translator

This block is a 4 KB memory-mapped register frame that converts message-signalled interrupt writes into pulses on a bank of dedicated interrupt lines. A device writes an absolute interrupt number to the doorbell register. The frame subtracts the first number of its window from that value. When the result falls inside the window, the frame drives the matching output line high for exactly one clock cycle.

Software finds the window by reading a packed type register. An identification word and a zero-filled identification area complete the frame. Two parameters fix the window: `BASE_ID` (the first interrupt number is `BASE_ID + 32`) and `NUM_LINES`. An elaboration-time check rejects a line count of zero, a count above 128, and any window that would reach past interrupt number 1020.

The bus is 32 bits wide and little-endian. Each access is a single cycle and carries byte strobes. Read data and the error strobe are registered and appear in the cycle after the access.

Top module: `msi_doorbell_xlate`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `irq_out`, `bus_err` and `bus_rdata` are all zero. `bus_rdata` is zero in every cycle that does not follow an accepted read.
- R2: A full-word read (`bus_be` = 4'b1111) at offset 0x008 returns `BASE_ID + 32` in bits [31:16] and `NUM_LINES` in bits [15:0], one cycle after the read.
- R3: A write at offset 0x040 with `bus_be` of 4'b1111 (full word) or 4'b0011 (low halfword) takes `bus_wdata[9:0]` as an interrupt number. The frame ignores all higher data bits. An in-window number N drives `irq_out[N - (BASE_ID + 32)]` high in the following cycle.
- R4: A doorbell number below `BASE_ID + 32`, or at or above `BASE_ID + 32 + NUM_LINES`, produces no pulse and no error.
- R5: Each pulse lasts exactly one cycle, and at most one line is high in any cycle. Doorbell writes on consecutive cycles each produce their own pulse.
- R6: A full-word read at offset 0xFCC returns `ID_CODE` in bits [31:20], with bits [19:0] reading as zero.
- R7: A full-word read at any word-aligned offset from 0xFD0 to 0xFFC returns zero and raises no error.
- R8: The frame accepts a read only with `bus_be` = 4'b1111. A write counts as a valid size only with `bus_be` 4'b0011 or 4'b1111. Any other read returns zero and raises `bus_err` for one cycle. Any other write has no effect and raises `bus_err` for one cycle. A 4'b1100 write is the halfword at offset +2 and decodes to no register.
- R9: The following accesses read zero, or have no effect if they are writes, and raise `bus_err` for one cycle: an offset that is not word aligned, an undecoded offset, a read of the doorbell, and a write to any register other than the doorbell.
- R10: An access with `bus_rd` and `bus_wr` both high has no effect, returns zero read data and raises `bus_err` for one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read enable, one cycle per access |
| bus_wr | input | 1 | Write enable, one cycle per access |
| bus_addr | input | 12 | Byte offset within the frame |
| bus_be | input | 4 | Byte strobes, bit 0 = lowest byte lane |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after a read |
| bus_err | output | 1 | One-cycle strobe for a bad access |
| irq_out | output | NUM_LINES | One-cycle interrupt pulses, one line per window entry |

## Verification
The bench builds the frame with `BASE_ID` = 40 and `NUM_LINES` = 16, so the window spans interrupt numbers 72 to 87. The nonzero base puts a real subtraction in the path. It also places in-range numbers next to rejected ones on both sides: 71 and 88 are rejected, and so are 0 and 1023 at the ends of the 10-bit field. The small line count keeps the upper-edge case and the highest line reachable with a handful of writes. Data bits above bit 9 are set on one doorbell write to show that the frame ignores them.

// File: rtl/msi_xlate_pkg.sv
package msi_xlate_pkg;

  localparam int FRAME_BYTES = 4096;
  localparam int ADDR_W      = $clog2(FRAME_BYTES);
  localparam int DATA_W      = 32;
  localparam int STRB_W      = DATA_W / 8;
  localparam int ID_W        = 10;
  localparam int ID_OFFSET   = 32;
  localparam int MAX_LINES   = 128;
  localparam int ID_LIMIT    = 1020;

  localparam logic [ADDR_W-1:0] OFS_TYPE     = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_BELL     = 12'h040;
  localparam logic [ADDR_W-1:0] OFS_IDENT    = 12'hFCC;
  localparam logic [ADDR_W-1:0] OFS_ZERO_LO  = 12'hFD0;
  localparam logic [ADDR_W-1:0] OFS_ZERO_HI  = 12'hFFC;

  localparam logic [STRB_W-1:0] STRB_WORD    = 4'b1111;
  localparam logic [STRB_W-1:0] STRB_HALF_LO = 4'b0011;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_RD_TYPE,
    ACC_RD_IDENT,
    ACC_RD_ZERO,
    ACC_WR_BELL,
    ACC_BAD
  } acc_kind_e;

endpackage

// File: rtl/msi_access_decode.sv
module msi_access_decode
  import msi_xlate_pkg::*;
(
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [STRB_W-1:0] be,
  output acc_kind_e         kind
);

  logic aligned;
  logic in_zero_area;

  assign aligned      = (addr[1:0] == 2'b00);
  assign in_zero_area = aligned && (addr >= OFS_ZERO_LO) && (addr <= OFS_ZERO_HI);

  always_comb begin
    kind = ACC_NONE;
    if (rd && wr) begin
      kind = ACC_BAD;
    end else if (rd) begin
      if (be != STRB_WORD)        kind = ACC_BAD;
      else if (addr == OFS_TYPE)  kind = ACC_RD_TYPE;
      else if (addr == OFS_IDENT) kind = ACC_RD_IDENT;
      else if (in_zero_area)      kind = ACC_RD_ZERO;
      else                        kind = ACC_BAD;
    end else if (wr) begin
      if ((addr == OFS_BELL) && ((be == STRB_WORD) || (be == STRB_HALF_LO)))
        kind = ACC_WR_BELL;
      else
        kind = ACC_BAD;
    end
  end

endmodule

// File: rtl/msi_id_window.sv
module msi_id_window
  import msi_xlate_pkg::*;
#(
  parameter int BASE_ID   = 0,
  parameter int NUM_LINES = 64,
  parameter int IDX_W     = 6
) (
  input  logic [ID_W-1:0]  id,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);

  localparam int FIRST_ID = BASE_ID + ID_OFFSET;

  int offset;

  always_comb begin
    offset = int'(id) - FIRST_ID;
    hit    = (offset >= 0) && (offset < NUM_LINES);
    idx    = IDX_W'(offset);
  end

endmodule

// File: rtl/msi_pulse_bank.sv
module msi_pulse_bank #(
  parameter int NUM_LINES = 64,
  parameter int IDX_W     = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fire,
  input  logic [IDX_W-1:0]     idx,
  output logic [NUM_LINES-1:0] lines
);

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) lines[g] <= 1'b0;
      else     lines[g] <= fire && (idx == IDX_W'(g));
    end
  end

endmodule

// File: rtl/msi_doorbell_xlate.sv
module msi_doorbell_xlate
  import msi_xlate_pkg::*;
#(
  parameter int          BASE_ID   = 0,
  parameter int          NUM_LINES = 64,
  parameter logic [11:0] ID_CODE   = 12'h2C5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [11:0]          bus_addr,
  input  logic [3:0]           bus_be,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 bus_err,
  output logic [NUM_LINES-1:0] irq_out
);

  localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam int FIRST_ID = BASE_ID + ID_OFFSET;
  localparam logic [DATA_W-1:0] TYPE_WORD  = {16'(FIRST_ID), 16'(NUM_LINES)};
  localparam logic [DATA_W-1:0] IDENT_WORD = {ID_CODE, 20'h0};

  if ((NUM_LINES < 1) || (NUM_LINES > MAX_LINES) || (BASE_ID < 0) ||
      (FIRST_ID + NUM_LINES > ID_LIMIT)) begin : g_bad_params
    $error("msi_doorbell_xlate: illegal BASE_ID/NUM_LINES combination");
  end

  acc_kind_e        kind;
  logic             win_hit;
  logic [IDX_W-1:0] win_idx;
  logic             fire;
  logic             wdata_unused;

  assign wdata_unused = ^bus_wdata[DATA_W-1:ID_W];

  msi_access_decode u_decode (
    .rd   (bus_rd),
    .wr   (bus_wr),
    .addr (bus_addr),
    .be   (bus_be),
    .kind (kind)
  );

  msi_id_window #(
    .BASE_ID   (BASE_ID),
    .NUM_LINES (NUM_LINES),
    .IDX_W     (IDX_W)
  ) u_window (
    .id  (bus_wdata[ID_W-1:0]),
    .hit (win_hit),
    .idx (win_idx)
  );

  assign fire = (kind == ACC_WR_BELL) && win_hit;

  msi_pulse_bank #(
    .NUM_LINES (NUM_LINES),
    .IDX_W     (IDX_W)
  ) u_pulses (
    .clk   (clk),
    .rst   (rst),
    .fire  (fire),
    .idx   (win_idx),
    .lines (irq_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_err <= (kind == ACC_BAD);
      case (kind)
        ACC_RD_TYPE:  bus_rdata <= TYPE_WORD;
        ACC_RD_IDENT: bus_rdata <= IDENT_WORD;
        default:      bus_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/msi_xlate_checker.sv
module msi_xlate_checker #(
  parameter int BASE_ID   = 0,
  parameter int NUM_LINES = 64
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_rd,
  input logic                 bus_wr,
  input logic [11:0]          bus_addr,
  input logic [3:0]           bus_be,
  input logic [31:0]          bus_wdata,
  input logic [31:0]          bus_rdata,
  input logic                 bus_err,
  input logic [NUM_LINES-1:0] irq_out
);

  localparam int LOW_ID  = BASE_ID + 32;
  localparam int HIGH_ID = LOW_ID + NUM_LINES;

  logic bell_full;
  logic id_outside;

  assign bell_full  = bus_wr && !bus_rd && (bus_addr == 12'h040) && (bus_be == 4'hF);
  assign id_outside = (int'(bus_wdata[9:0]) < LOW_ID) || (int'(bus_wdata[9:0]) >= HIGH_ID);

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (irq_out == '0 && !bus_err && bus_rdata == '0)); // R1

  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0)); // R1

  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (irq_out != '0) |-> $past(bus_wr && !bus_rd && bus_addr == 12'h040)); // R3

  AST_WINDOW_DROP: assert property (@(posedge clk) disable iff (rst)
    (bell_full && id_outside) |=> (irq_out == '0 && !bus_err)); // R4

  AST_ONE_LINE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq_out)); // R5

  AST_BAD_READ_SIZE: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && bus_be != 4'hF) |=> (bus_err && bus_rdata == '0)); // R8

  AST_RD_WR_CLASH: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_wr) |=> (bus_err && irq_out == '0 && bus_rdata == '0)); // R10

endmodule

bind msi_doorbell_xlate msi_xlate_checker #(
  .BASE_ID   (BASE_ID),
  .NUM_LINES (NUM_LINES)
) u_xlate_checker (.*);

// File: tb/msi_doorbell_xlate_bench.sv
module msi_doorbell_xlate_bench;

  localparam int          BASE  = 40;
  localparam int          NL    = 16;
  localparam int          FIRST = BASE + 32;
  localparam logic [11:0] CODE  = 12'h6B3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rd = 1'b0, wr = 1'b0;
  logic [11:0]   addr = '0;
  logic [3:0]    be = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          err;
  logic [NL-1:0] irq;

  logic [NL-1:0] exp_irq;
  logic [31:0]   exp_rdata;
  logic          exp_err;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  msi_doorbell_xlate #(
    .BASE_ID   (BASE),
    .NUM_LINES (NL),
    .ID_CODE   (CODE)
  ) u_msi_doorbell_xlate (
    .clk       (clk),
    .rst       (rst),
    .bus_rd    (rd),
    .bus_wr    (wr),
    .bus_addr  (addr),
    .bus_be    (be),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .bus_err   (err),
    .irq_out   (irq)
  );

  // Behavioural reference: what the outputs must show one cycle after this access.
  task automatic predict();
    int id;
    int line;
    exp_irq   = '0;
    exp_rdata = '0;
    exp_err   = 1'b0;
    if (rst) return;
    if (rd && wr) begin
      exp_err = 1'b1;
    end else if (rd) begin
      if (be != 4'hF) exp_err = 1'b1;
      else if (addr == 12'h008) exp_rdata = (32'(FIRST) << 16) | 32'(NL);
      else if (addr == 12'hFCC) exp_rdata = {CODE, 20'h0};
      else if (addr >= 12'hFD0 && addr <= 12'hFFC && addr % 4 == 0) exp_rdata = '0;
      else exp_err = 1'b1;
    end else if (wr) begin
      if (addr == 12'h040 && (be == 4'hF || be == 4'h3)) begin
        id   = int'(wdata % 1024);
        line = id - FIRST;
        if (line >= 0 && line < NL) exp_irq[line] = 1'b1;
      end else begin
        exp_err = 1'b1;
      end
    end
  endtask

  // Called at a falling edge: drive, predict, then compare at the next falling edge.
  task automatic step(input string req, input logic r, input logic w,
                      input logic [11:0] a, input logic [3:0] b, input logic [31:0] d);
    rd = r; wr = w; addr = a; be = b; wdata = d;
    predict();
    @(negedge clk);
    checks++;
    if (irq !== exp_irq || rdata !== exp_rdata || err !== exp_err) begin
      fails++;
      $display("FAIL %s: irq=%h exp %h, rdata=%h exp %h, err=%b exp %b",
               req, irq, exp_irq, rdata, exp_rdata, err, exp_err);
    end
  endtask

  task automatic idle(input string req);
    step(req, 1'b0, 1'b0, 12'h000, 4'h0, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, actual hung, expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: access attempts during reset leave all outputs low
    step("R1", 1'b0, 1'b1, 12'h040, 4'hF, 32'(FIRST));
    step("R1", 1'b1, 1'b0, 12'h008, 4'hF, 32'h0);
    rst = 1'b0;
    idle("R1");
    // R2: type register
    step("R2", 1'b1, 1'b0, 12'h008, 4'hF, 32'h0);
    idle("R1");
    // R6: identification word
    step("R6", 1'b1, 1'b0, 12'hFCC, 4'hF, 32'h0);
    // R7: zero-filled identification area
    step("R7", 1'b1, 1'b0, 12'hFD0, 4'hF, 32'h0);
    step("R7", 1'b1, 1'b0, 12'hFE4, 4'hF, 32'h0);
    step("R7", 1'b1, 1'b0, 12'hFFC, 4'hF, 32'h0);
    // R3: in-window doorbells, full word and low halfword, high data bits ignored
    step("R3", 1'b0, 1'b1, 12'h040, 4'hF, 32'(FIRST));
    idle("R3");
    step("R3", 1'b0, 1'b1, 12'h040, 4'h3, 32'(FIRST + NL - 1));
    idle("R3");
    step("R3", 1'b0, 1'b1, 12'h040, 4'hF, 32'hFFFF_FC4D);
    idle("R3");
    // R4: numbers just outside the window and at the field ends
    step("R4", 1'b0, 1'b1, 12'h040, 4'hF, 32'(FIRST - 1));
    step("R4", 1'b0, 1'b1, 12'h040, 4'hF, 32'(FIRST + NL));
    step("R4", 1'b0, 1'b1, 12'h040, 4'hF, 32'd0);
    step("R4", 1'b0, 1'b1, 12'h040, 4'hF, 32'd1023);
    idle("R4");
    // R5: back-to-back doorbells each give their own single-cycle pulse
    step("R5", 1'b0, 1'b1, 12'h040, 4'hF, 32'(FIRST + 1));
    step("R5", 1'b0, 1'b1, 12'h040, 4'hF, 32'(FIRST + 2));
    step("R5", 1'b0, 1'b1, 12'h040, 4'h3, 32'(FIRST + 3));
    idle("R5");
    idle("R5");
    // R8: bad access sizes
    step("R8", 1'b1, 1'b0, 12'h008, 4'h3, 32'h0);
    step("R8", 1'b0, 1'b1, 12'h040, 4'h1, 32'(FIRST));
    step("R8", 1'b0, 1'b1, 12'h040, 4'hC, 32'(FIRST));
    step("R8", 1'b1, 1'b0, 12'hFD0, 4'h0, 32'h0);
    idle("R8");
    // R9: undecoded offsets, misalignment, wrong direction
    step("R9", 1'b1, 1'b0, 12'h040, 4'hF, 32'h0);
    step("R9", 1'b0, 1'b1, 12'h008, 4'hF, 32'(FIRST));
    step("R9", 1'b1, 1'b0, 12'h00A, 4'hF, 32'h0);
    step("R9", 1'b1, 1'b0, 12'h100, 4'hF, 32'h0);
    step("R9", 1'b0, 1'b1, 12'hFD0, 4'hF, 32'h0);
    step("R9", 1'b0, 1'b1, 12'h042, 4'hF, 32'(FIRST));
    idle("R9");
    // R10: simultaneous read and write
    step("R10", 1'b1, 1'b1, 12'h040, 4'hF, 32'(FIRST));
    step("R10", 1'b1, 1'b1, 12'h008, 4'hF, 32'h0);
    idle("R10");
    // R1: reset in mid-run clears a pending pulse
    step("R1", 1'b0, 1'b1, 12'h040, 4'hF, 32'(FIRST + 4));
    rst = 1'b1;
    step("R1", 1'b0, 1'b1, 12'h040, 4'hF, 32'(FIRST + 5));
    rst = 1'b0;
    idle("R1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule